// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the bit-level front end of a byte-addressed nonvolatile memory that answers on a four-wire synchronous serial bus. It always acts as the slave: the serial clock, select, data-in and pause lines are plain inputs. All four are brought into the faster system clock domain through synchroniser chains, and their edges are found on the synchronised values. Incoming bits are sampled on rising serial clock edges and assembled most significant bit first. Each finished byte is handed to a command engine with a one-cycle strobe and a flag that marks the first byte of the selection, which is the opcode.

Outgoing bytes come from the same engine. On the first falling serial clock edge after a byte completes, the block takes the engine's next byte, pulses a fetch strobe, and drives that byte out MSB first, one bit per falling edge. Clock idle-low (mode 0) and clock idle-high (mode 3) both work without any mode setting. A pause input freezes the transfer at its current bit without losing its place, and a reject input from the engine silences the rest of the selection.

Top module: `serial_mem_front`

## Requirements
- R1: After reset the output enable `ser_dout_en` is low and `rx_strobe` and `tx_fetch` are low.
- R2: While selected and neither paused nor rejected, every eighth rising edge of `ser_clk` makes `rx_strobe` high for exactly one cycle, with `rx_data` holding the eight `ser_din` values sampled on those edges, the first-sampled bit in bit 7.
- R3: `rx_is_first` is 1 with the first byte strobed after `sel_n` falls and 0 with every later byte of the same selection.
- R4: While `sel_n` is high, `ser_dout_en` is low and `ser_clk` and `ser_din` activity produces no byte strobe.
- R5: A rise of `sel_n` discards a partly received byte; the next selection assembles its first byte from its own first eight bits.
- R6: On the first falling `ser_clk` edge after a byte completes, `tx_data` is taken (one-cycle `tx_fetch` pulse) and its bit 7 is presented on `ser_dout`; each later falling edge presents the next lower bit. `ser_dout_en` is high from that load only if `tx_drive` was 1 at the load, and never during the first byte of a selection.
- R7: The pause state is entered only when `pause_n` falls while `ser_clk` is low; while paused `ser_dout_en` is low, clock edges are ignored, and bit position and output bit are kept.
- R8: The pause state is left only when `pause_n` rises while `ser_clk` is low, or when `sel_n` rises.
- R9: A one-cycle `cmd_reject` during a selection keeps `ser_dout_en` low and stops all byte strobes until the next fall of `sel_n`.
- R10: With `ser_clk` high when `sel_n` falls (mode 3), bytes are received and sent exactly as in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the bus master |
| sel_n | input | 1 | Active-low select |
| ser_din | input | 1 | Serial data from the master |
| pause_n | input | 1 | Active-low pause request |
| ser_dout | output | 1 | Serial data to the master (valid when enabled) |
| ser_dout_en | output | 1 | Output enable; low means the pin floats |
| cmd_reject | input | 1 | Pulse from the engine: current opcode is invalid |
| tx_data | input | 8 | Next byte to send |
| tx_drive | input | 1 | Engine wants the next byte actually driven |
| tx_fetch | output | 1 | One-cycle pulse when `tx_data` is taken |
| rx_data | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse: `rx_data` is new |
| rx_is_first | output | 1 | The strobed byte is the opcode |

## Verification
The assertions watch, on every cycle, that pause is entered and left only with the synchronised clock low or on deselection, that byte and fetch strobes never last two cycles, that the bit counter is cleared whenever the block is deselected, and that no byte strobe appears while deselected or rejected. Whether bytes are assembled in the right order, whether the output stream continues at the right bit after a pause, and how mode 3 lines up with mode 0 are only visible from the bench, which runs master transfers in both modes and compares every cycle against a behavioural model as well as the bytes the master sees.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   // Bundled bus inputs, synchronised together.
   typedef struct packed {
      logic sclk;
      logic seln;
      logic din;
      logic pausen;
   } pad_t;

   localparam pad_t PAD_IDLE = '{sclk: 1'b0, seln: 1'b1, din: 1'b0, pausen: 1'b1};
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int unsigned W       = 4,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sfe_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sfe_hold.sv
module sfe_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic sclk_s,
   input  logic pause_s,
   input  logic pause_p,
   output logic held
);
   logic pause_fall, pause_rise;
   assign pause_fall = pause_p & ~pause_s;
   assign pause_rise = ~pause_p & pause_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 held <= 1'b0;
      else if (!active)                           held <= 1'b0;
      else if (!held && pause_fall && !sclk_s)    held <= 1'b1;
      else if (held && pause_rise && !sclk_s)     held <= 1'b0;
   end

   assert_hold_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held) |-> ($past(sclk_s) == 1'b0));

   assert_hold_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(held) |-> (($past(sclk_s) == 1'b0) || ($past(active) == 1'b0)));
endmodule

// File: rtl/sfe_shift.sv
module sfe_shift #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              run,
   input  logic              clk_rise,
   input  logic              clk_fall,
   input  logic              din,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_drive,
   output logic              tx_fetch,
   output logic              drive_q,
   output logic              dout,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_strobe,
   output logic              rx_is_first
);
   localparam int unsigned CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rx_sr, tx_sr;
   logic              first_q, pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0; rx_sr <= '0; tx_sr <= '0; rx_data <= '0;
         first_q <= 1'b1; pend_q <= 1'b0; drive_q <= 1'b0;
         rx_strobe <= 1'b0; rx_is_first <= 1'b0; tx_fetch <= 1'b0;
      end else if (!active) begin
         cnt <= '0; first_q <= 1'b1; pend_q <= 1'b0; drive_q <= 1'b0;
         rx_strobe <= 1'b0; tx_fetch <= 1'b0;
      end else begin
         rx_strobe <= 1'b0;
         tx_fetch  <= 1'b0;
         if (run && clk_rise) begin
            rx_sr <= {rx_sr[DATA_W-2:0], din};
            if (cnt == LAST) begin
               cnt         <= '0;
               rx_data     <= {rx_sr[DATA_W-2:0], din};
               rx_strobe   <= 1'b1;
               rx_is_first <= first_q;
               first_q     <= 1'b0;
               pend_q      <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (run && clk_fall) begin
            if (pend_q) begin
               tx_sr    <= tx_data;
               drive_q  <= tx_drive;
               tx_fetch <= 1'b1;
               pend_q   <= 1'b0;
            end else begin
               tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign dout = tx_sr[DATA_W-1];

   assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

   assert_fetch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fetch |=> !tx_fetch);

   assert_count_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0));
endmodule

// File: rtl/serial_mem_front.sv
module serial_mem_front
   import sfe_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              sel_n,
   input  logic              ser_din,
   input  logic              pause_n,
   output logic              ser_dout,
   output logic              ser_dout_en,
   input  logic              cmd_reject,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_drive,
   output logic              tx_fetch,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_strobe,
   output logic              rx_is_first
);
   if (DATA_W < 2) begin : g_bad_width
      $error("serial_mem_front: DATA_W must be at least 2");
   end

   pad_t pad_raw, pad_s;
   logic sclk_p, seln_p, pause_p;
   logic active, sel_fall, clk_rise, clk_fall;
   logic held, rej_q, run, drive_q;

   assign pad_raw = '{sclk: ser_clk, seln: sel_n, din: ser_din, pausen: pause_n};

   sfe_sync #(.W($bits(pad_t)), .STAGES(SYNC_STAGES), .RST_VAL(PAD_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_raw), .q(pad_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= PAD_IDLE.sclk; seln_p <= PAD_IDLE.seln; pause_p <= PAD_IDLE.pausen;
      end else begin
         sclk_p <= pad_s.sclk; seln_p <= pad_s.seln; pause_p <= pad_s.pausen;
      end
   end

   assign active   = ~pad_s.seln;
   assign sel_fall = seln_p & ~pad_s.seln;
   assign clk_rise = active & ~sclk_p & pad_s.sclk;
   assign clk_fall = active & sclk_p & ~pad_s.sclk;

   // Reject latch: held until the next selection begins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rej_q <= 1'b0;
      else if (sel_fall)              rej_q <= 1'b0;
      else if (active && cmd_reject)  rej_q <= 1'b1;
   end

   sfe_hold u_hold (
      .clk(clk), .rst_n(rst_n), .active(active), .sclk_s(pad_s.sclk),
      .pause_s(pad_s.pausen), .pause_p(pause_p), .held(held));

   assign run = ~held & ~rej_q;

   sfe_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(active), .run(run),
      .clk_rise(clk_rise), .clk_fall(clk_fall), .din(pad_s.din),
      .tx_data(tx_data), .tx_drive(tx_drive), .tx_fetch(tx_fetch),
      .drive_q(drive_q), .dout(ser_dout), .rx_data(rx_data),
      .rx_strobe(rx_strobe), .rx_is_first(rx_is_first));

   assign ser_dout_en = active & drive_q & ~held & ~rej_q;

   assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rej_q |=> !rx_strobe);

   assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_s.seln && seln_p) |=> !rx_strobe);
endmodule

// File: tb/serial_mem_front_test.sv
module serial_mem_front_test;
   localparam int H = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, sel_n = 1'b1, ser_din = 1'b0, pause_n = 1'b1;
   logic cmd_reject = 1'b0, tx_drive = 1'b1;
   logic [7:0] tx_data = 8'h3C;
   logic ser_dout, ser_dout_en, tx_fetch, rx_strobe, rx_is_first;
   logic [7:0] rx_data;

   int checks = 0, failures = 0, strobe_cnt = 0;
   bit oe_hit = 0, reject_arm = 0, done = 0;
   logic [8:0] rxq [$];

   always #4 clk = ~clk;

   serial_mem_front uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .ser_din(ser_din),
      .pause_n(pause_n), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
      .cmd_reject(cmd_reject), .tx_data(tx_data), .tx_drive(tx_drive),
      .tx_fetch(tx_fetch), .rx_data(rx_data), .rx_strobe(rx_strobe),
      .rx_is_first(rx_is_first));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Command engine stand-in.
   always @(posedge clk) begin
      if (tx_fetch) tx_data <= tx_data + 8'h11;
      cmd_reject <= reject_arm && rx_strobe && rx_is_first && (rx_data == 8'hFF);
   end

   // Behavioural reference: pads seen after a two-cycle delay, edges vs. previous.
   localparam logic [3:0] IDLE = 4'b0101; // {clk, sel_n, din, pause_n}
   logic [3:0] h1 = IDLE, h2 = IDLE, h3 = IDLE;
   int m_cnt = 0;
   logic [7:0] m_sr = 0, m_tx = 0, m_rxb = 0;
   bit m_first = 1, m_pend = 0, m_drive = 0, m_held = 0, m_rej = 0;
   bit m_rxv = 0, m_rxf = 0, m_take = 0;

   always @(posedge clk) begin
      logic [3:0] s, p;
      bit act, run;
      if (!rst_n) begin
         h1 = IDLE; h2 = IDLE; h3 = IDLE;
         m_cnt = 0; m_sr = 0; m_tx = 0; m_rxb = 0; m_first = 1; m_pend = 0;
         m_drive = 0; m_held = 0; m_rej = 0; m_rxv = 0; m_rxf = 0; m_take = 0;
      end else begin
         s = h2; p = h3;
         m_rxv = 0; m_take = 0;
         act = !s[2];
         run = !m_held && !m_rej;
         if (!act) begin
            m_cnt = 0; m_first = 1; m_pend = 0; m_drive = 0;
         end else begin
            if (run && !p[3] && s[3]) begin
               m_sr = {m_sr[6:0], s[1]};
               if (m_cnt == 7) begin
                  m_cnt = 0; m_rxv = 1; m_rxb = m_sr; m_rxf = m_first;
                  m_first = 0; m_pend = 1;
               end else m_cnt++;
            end
            if (run && p[3] && !s[3]) begin
               if (m_pend) begin
                  m_tx = tx_data; m_drive = tx_drive; m_take = 1; m_pend = 0;
               end else m_tx = {m_tx[6:0], 1'b0};
            end
         end
         if (!act) m_held = 0;
         else if (!m_held && p[0] && !s[0] && !s[3]) m_held = 1;
         else if (m_held && !p[0] && s[0] && !s[3]) m_held = 0;
         if (p[2] && !s[2]) m_rej = 0;
         else if (act && cmd_reject) m_rej = 1;
         h3 = h2; h2 = h1; h1 = {ser_clk, sel_n, ser_din, pause_n};
      end
   end

   // Per-cycle comparison and monitors.
   always @(negedge clk) begin
      bit oe_exp;
      if (rst_n) begin
         oe_exp = !h2[2] && m_drive && !m_held && !m_rej;
         check("R6/R7 model oe", ser_dout_en, oe_exp);
         if (oe_exp) check("R6 model dout", ser_dout, m_tx[7]);
         check("R2 model strobe", rx_strobe, m_rxv);
         check("R6 model fetch", tx_fetch, m_take);
         if (m_rxv) begin
            check("R2 model data", rx_data, m_rxb);
            check("R3 model first", rx_is_first, m_rxf);
         end
         if (rx_strobe) begin strobe_cnt++; rxq.push_back({rx_is_first, rx_data}); end
         if (ser_dout_en) oe_hit = 1;
      end
   end

   task automatic wait_h(input int n = 1);
      repeat (n * H) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, output logic got, output logic oe);
      ser_clk = 1'b0; ser_din = b; wait_h();
      got = ser_dout; oe = ser_dout_en;
      ser_clk = 1'b1; wait_h();
   endtask

   task automatic xfer(input logic [7:0] out, input bit m3, output logic [7:0] in, output bit oe_any);
      logic g, o;
      oe_any = 0;
      for (int i = 7; i >= 0; i--) begin
         send_bit(out[i], g, o);
         in[i] = g; if (o) oe_any = 1;
      end
      if (!m3) begin ser_clk = 1'b0; wait_h(); end
   endtask

   task automatic begin_txn(input bit m3);
      ser_clk = m3; wait_h(); sel_n = 1'b0; wait_h();
   endtask

   task automatic end_txn();
      wait_h(); sel_n = 1'b1; wait_h(2);
   endtask

   task automatic expect_rx(input string tag, input bit first, input logic [7:0] data);
      logic [8:0] e;
      if (rxq.size() == 0) begin
         checks++; failures++;
         $display("FAIL %s actual=none expected=%0h", tag, {first, data});
      end else begin
         e = rxq.pop_front();
         check(tag, e, {first, data});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] r0, r1, r2, t0, b;
      bit oe0, oe1, oe2;
      logic g, o;
      int sc;

      repeat (5) @(negedge clk);
      check("R1 reset oe", ser_dout_en, 1'b0);
      check("R1 reset strobe", rx_strobe, 1'b0);
      check("R1 reset fetch", tx_fetch, 1'b0);
      rst_n = 1'b1;
      wait_h(2);

      // Mode 0 transaction with read-back.
      t0 = tx_data;
      begin_txn(0);
      xfer(8'h03, 0, r0, oe0);
      xfer(8'h12, 0, r1, oe1);
      xfer(8'h34, 0, r2, oe2);
      end_txn();
      expect_rx("R3 mode0 opcode", 1, 8'h03);
      expect_rx("R2 mode0 byte1", 0, 8'h12);
      expect_rx("R2 mode0 byte2", 0, 8'h34);
      check("R6 no drive in opcode byte", oe0, 1'b0);
      check("R6 readback byte1", r1, t0);
      check("R6 readback byte2", r2, t0 + 8'h11);

      // Mode 3 transaction.
      t0 = tx_data;
      begin_txn(1);
      xfer(8'hC3, 1, r0, oe0);
      xfer(8'h5A, 1, r1, oe1);
      xfer(8'h00, 1, r2, oe2);
      end_txn();
      expect_rx("R10 mode3 opcode", 1, 8'hC3);
      expect_rx("R10 mode3 byte1", 0, 8'h5A);
      expect_rx("R10 mode3 byte2", 0, 8'h00);
      check("R10 mode3 readback", r1, t0);
      check("R10 mode3 readback2", r2, t0 + 8'h11);

      // tx_drive low: byte taken but pin floats.
      tx_drive = 1'b0;
      begin_txn(0);
      xfer(8'h0B, 0, r0, oe0);
      xfer(8'hFE, 0, r1, oe1);
      end_txn();
      tx_drive = 1'b1;
      expect_rx("R3 undriven opcode", 1, 8'h0B);
      expect_rx("R2 undriven byte", 0, 8'hFE);
      check("R6 no drive when tx_drive low", oe1, 1'b0);

      // Deselected activity is ignored.
      sc = strobe_cnt; oe_hit = 0;
      for (int i = 0; i < 10; i++) begin
         ser_din = i[0]; ser_clk = 1'b1; wait_h(); ser_clk = 1'b0; wait_h();
      end
      check("R4 no strobe deselected", strobe_cnt, sc);
      check("R4 no drive deselected", oe_hit, 1'b0);

      // Partial byte aborted by deselect.
      begin_txn(0);
      for (int i = 0; i < 4; i++) send_bit(1'b1, g, o);
      ser_clk = 1'b0; wait_h();
      end_txn();
      begin_txn(0);
      xfer(8'h96, 0, r0, oe0);
      end_txn();
      check("R5 single strobe after abort", rxq.size(), 1);
      expect_rx("R5 aligned after abort", 1, 8'h96);

      // Proper pause in the middle of a byte (clock low).
      t0 = tx_data;
      begin_txn(0);
      xfer(8'hAB, 0, r0, oe0);
      b = 8'h5C;
      for (int i = 7; i >= 4; i--) begin send_bit(b[i], g, o); r1[i] = g; end
      ser_clk = 1'b0; wait_h();
      pause_n = 1'b0; wait_h();
      sc = strobe_cnt; oe_hit = 0;
      for (int i = 0; i < 6; i++) begin
         ser_din = ~i[0]; ser_clk = 1'b1; wait_h(); ser_clk = 1'b0; wait_h();
      end
      check("R7 no strobe while paused", strobe_cnt, sc);
      check("R7 floating while paused", oe_hit, 1'b0);
      pause_n = 1'b1; wait_h();
      for (int i = 3; i >= 0; i--) begin send_bit(b[i], g, o); r1[i] = g; end
      ser_clk = 1'b0; wait_h();
      end_txn();
      expect_rx("R3 pause opcode", 1, 8'hAB);
      expect_rx("R7 byte position kept", 0, 8'h5C);
      check("R7 output position kept", r1, t0);

      // Pause request with clock high is not a pause (mode 3 idle high).
      begin_txn(1);
      pause_n = 1'b0; wait_h();
      xfer(8'h71, 1, r0, oe0);
      ser_clk = 1'b0; wait_h();
      pause_n = 1'b1; wait_h();
      ser_clk = 1'b1; wait_h();
      end_txn();
      expect_rx("R7 no pause when clock high", 1, 8'h71);

      // Pause release with clock high is ignored.
      begin_txn(0);
      pause_n = 1'b0; wait_h();
      ser_clk = 1'b1; wait_h();
      pause_n = 1'b1; wait_h();
      ser_clk = 1'b0; wait_h();
      sc = strobe_cnt;
      xfer(8'h44, 0, r0, oe0);
      check("R8 still paused after high-clock release", strobe_cnt, sc);
      end_txn();
      begin_txn(0);
      xfer(8'h45, 0, r0, oe0);
      end_txn();
      expect_rx("R8 deselect ends pause", 1, 8'h45);

      // Rejected opcode silences the selection.
      reject_arm = 1;
      begin_txn(0);
      xfer(8'hFF, 0, r0, oe0);
      sc = strobe_cnt; oe_hit = 0;
      xfer(8'h11, 0, r1, oe1);
      xfer(8'h22, 0, r2, oe2);
      check("R9 no strobe after reject", strobe_cnt, sc);
      check("R9 floating after reject", oe_hit, 1'b0);
      end_txn();
      reject_arm = 0;
      expect_rx("R9 rejected opcode seen", 1, 8'hFF);
      begin_txn(0);
      xfer(8'h03, 0, r0, oe0);
      xfer(8'h66, 0, r1, oe1);
      end_txn();
      expect_rx("R9 cleared by new select", 1, 8'h03);
      expect_rx("R9 cleared byte", 0, 8'h66);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule